// File: doc/BRIEF.md
# Horizontal Window and Fractional Source-Column Scaler

This block sits beside the raster timing of a 640 by 480 display and works out, column by column, where the visible window lies and which source pixel belongs in each column. The timing generator supplies the current column with a valid strobe and a pulse at the start of each line. For every valid column the block reports one cycle later whether the column is inside the window or is border, together with the integer source column that a later pixel-fetch stage should show there.

The window edges are kept as 8-bit values that count in units of four columns, so the full 640-column line spans 0 to 160. Horizontal scaling uses an 8-bit step in fixed point with seven fractional bits. A step of 128 maps each output column to its own source pixel, a step of 64 shows each source pixel twice, and other values repeat source pixels by fractional amounts. The block also holds three display enable flags, for two tile or bitmap layers and for sprites. A bank bit in a control register decides which of two registers a shared address reaches.

Top module: `hws_top`

## Requirements
- R1: After reset the start value is 0, the stop value is 160, the scale step is 128, all three enable flags are 0 and the bank bit is 0.
- R2: Register addresses: address 0 is control, with the bank bit in bit 0 and the other bits reading 0. When the bank bit is 0, address 1 reaches the display-enable register and address 2 the scale step. When it is 1, address 1 reaches the start value and address 2 the stop value. Address 3 reads 0 and ignores writes. A write changes only the register that its address reaches under the current bank bit.
- R3: In the display-enable register, bit 4 drives `layer0_en`, bit 5 drives `layer1_en` and bit 6 drives `sprite_en`. Its other bits read back as 0.
- R4: A column is inside the window when start×4 ≤ col < stop×4. For a valid column exactly one of `out_active` and `out_border` is 1. When stop ≤ start every column is border.
- R5: A `line_start` pulse clears the source-position accumulator, including in the middle of a line. The first active column after it reports source column 0.
- R6: Each active column adds the scale step to the accumulator after its own source column has been reported. `out_src` is the accumulator shifted right by 7, so a step of 128 gives source = k and a step of 64 gives source = k/2 (rounded down) for the k-th active column, counting from 0.
- R7: Border columns do not advance the accumulator. The source column after a border stretch carries on from where it stopped.
- R8: The outputs for a column are registered and appear on the cycle after `col_valid`. When no column was presented, `out_valid`, `out_active` and `out_border` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at `reg_addr` (combinational) |
| col_valid | input | 1 | `col` carries a display column this cycle |
| col | input | 10 | Current display column, 0 to 639 |
| line_start | input | 1 | Start-of-line pulse; clears the accumulator |
| out_valid | output | 1 | Outputs below describe the column presented last cycle |
| out_active | output | 1 | That column is inside the window |
| out_border | output | 1 | That column is outside the window |
| out_src | output | 11 | Source column for that column |
| layer0_en | output | 1 | Layer 0 enable flag |
| layer1_en | output | 1 | Layer 1 enable flag |
| sprite_en | output | 1 | Sprite enable flag |

## Verification
The hardest case to reach from the ports is an accumulator that must hold its value across a border stretch and then carry on. A default window never shows it, and a register write that lands on the wrong bank can hide it. The stimulus sets the bank bit to reach the start and stop values, narrows the window on both sides and uses a non-power-of-two step. It also sends a second line-start pulse in the middle of a line, so that a reset of the accumulator and a held accumulator can be told apart in the source-column sequence.

// File: rtl/hws_pkg.sv
// Package: shared widths, register addresses and reset values for the
// horizontal window scaler. Assumes a 640-column line and edges counted in
// units of four columns.
package hws_pkg;
    localparam int COL_W      = 10;  // display column width
    localparam int SCALE_W    = 8;   // scale step width
    localparam int FRAC_W     = 7;   // fractional bits of the accumulator
    localparam int EDGE_W     = 8;   // window edge register width
    localparam int EDGE_SHIFT = 2;   // edge register counts units of 4 columns
    localparam int DATA_W     = 8;   // register data width
    localparam int ADDR_W     = 2;   // register address width
    localparam int ACC_W      = COL_W + SCALE_W;
    localparam int SRC_W      = ACC_W - FRAC_W;
    localparam int FLAG_LO    = 4;   // display-enable flags sit at bits 4..6
    localparam int FLAG_N     = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 2'd0,
        RA_SHR_A = 2'd1,
        RA_SHR_B = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    localparam logic [EDGE_W-1:0]  START_RST = 8'd0;
    localparam logic [EDGE_W-1:0]  STOP_RST  = 8'd160;
    localparam logic [SCALE_W-1:0] SCALE_RST = 8'd128;
endpackage

// File: rtl/hws_regs.sv
// Register bank: control (bank bit), display-enable flags, scale step and the
// two window edges. Two addresses are shared and steered by the bank bit.
// Assumes single-cycle writes; reads are combinational.
module hws_regs
    import hws_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [EDGE_W-1:0]   start_q,
    output logic [EDGE_W-1:0]   stop_q,
    output logic [SCALE_W-1:0]  scale_q,
    output logic [FLAG_N-1:0]   flags_q
);
    logic bank_q;
    logic sel_ctrl, sel_flags, sel_scale, sel_start, sel_stop;
    logic [DATA_W-1:0] flags_byte;

    // decode which register the address reaches under the current bank
    always_comb begin
        sel_ctrl  = (addr == RA_CTRL);
        sel_flags = (addr == RA_SHR_A) && !bank_q;
        sel_start = (addr == RA_SHR_A) &&  bank_q;
        sel_scale = (addr == RA_SHR_B) && !bank_q;
        sel_stop  = (addr == RA_SHR_B) &&  bank_q;
    end

    // place the flag bits at their byte position for read-back
    always_comb begin
        flags_byte = '0;
        flags_byte[FLAG_LO +: FLAG_N] = flags_q;
    end

    // control register: bank bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= 1'b0;
        else if (wr_en && sel_ctrl)
            bank_q <= wdata[0];
    end

    // display-enable flags
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (wr_en && sel_flags)
            flags_q <= wdata[FLAG_LO +: FLAG_N];
    end

    // scale step
    always_ff @(posedge clk) begin
        if (!rst_n)
            scale_q <= SCALE_RST;
        else if (wr_en && sel_scale)
            scale_q <= wdata[SCALE_W-1:0];
    end

    // window start edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= START_RST;
        else if (wr_en && sel_start)
            start_q <= wdata[EDGE_W-1:0];
    end

    // window stop edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_q <= STOP_RST;
        else if (wr_en && sel_stop)
            stop_q <= wdata[EDGE_W-1:0];
    end

    // read multiplexer
    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_CTRL:  rdata = {{(DATA_W-1){1'b0}}, bank_q};
            RA_SHR_A: rdata = bank_q ? DATA_W'(start_q) : flags_byte;
            RA_SHR_B: rdata = bank_q ? DATA_W'(stop_q)  : DATA_W'(scale_q);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/hws_window.sv
// Window comparator: flags a column that lies in [start*4, stop*4).
// Purely combinational; an empty window results when stop <= start.
module hws_window
    import hws_pkg::*;
(
    input  logic [COL_W-1:0]  col,
    input  logic [EDGE_W-1:0] start_q,
    input  logic [EDGE_W-1:0] stop_q,
    output logic              in_win
);
    localparam int LIM_W = EDGE_W + EDGE_SHIFT;

    logic [LIM_W-1:0] lo_lim, hi_lim;
    logic [LIM_W-1:0] col_ext;

    // expand the edges to columns and compare
    always_comb begin
        lo_lim  = {start_q, {EDGE_SHIFT{1'b0}}};
        hi_lim  = {stop_q,  {EDGE_SHIFT{1'b0}}};
        col_ext = LIM_W'(col);
        in_win  = (col_ext >= lo_lim) && (col_ext < hi_lim);
    end
endmodule

// File: rtl/hws_accum.sv
// Source-position accumulator: cleared by the line-start pulse, advanced by
// the scale step on each active column. The integer part is the source column.
// Assumes line_start has priority over a step in the same cycle.
module hws_accum
    import hws_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic [SCALE_W-1:0] scale_q,
    output logic [ACC_W-1:0]   acc_q,
    output logic [SRC_W-1:0]   src_col
);
    // accumulate, clear on line start
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clear)
            acc_q <= '0;
        else if (step)
            acc_q <= acc_q + ACC_W'(scale_q);
    end

    // integer part of the position
    always_comb src_col = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/hws_top.sv
// Horizontal window and fractional scaler top. Registers per-column results
// one cycle after col_valid. Assumes col stays within 0..639 and that
// line_start comes on a cycle without col_valid or is meant to restart.
module hws_top
    import hws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              col_valid,
    input  logic [9:0]        col,
    input  logic              line_start,
    output logic              out_valid,
    output logic              out_active,
    output logic              out_border,
    output logic [10:0]       out_src,
    output logic              layer0_en,
    output logic              layer1_en,
    output logic              sprite_en
);
    logic [EDGE_W-1:0]  start_q, stop_q;
    logic [SCALE_W-1:0] scale_q;
    logic [FLAG_N-1:0]  flags_q;
    logic               win_act;
    logic               do_step;
    logic [ACC_W-1:0]   acc_q;
    logic [SRC_W-1:0]   src_now;

    hws_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .start_q (start_q),
        .stop_q  (stop_q),
        .scale_q (scale_q),
        .flags_q (flags_q)
    );

    hws_window u_win (
        .col     (col),
        .start_q (start_q),
        .stop_q  (stop_q),
        .in_win  (win_act)
    );

    // step only on a presented, active column with no restart pending
    always_comb do_step = col_valid && win_act && !line_start;

    hws_accum u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (line_start),
        .step    (do_step),
        .scale_q (scale_q),
        .acc_q   (acc_q),
        .src_col (src_now)
    );

    // output stage: one registered result per presented column
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_active <= 1'b0;
            out_border <= 1'b0;
            out_src    <= '0;
        end else begin
            out_valid  <= col_valid;
            out_active <= col_valid &&  win_act;
            out_border <= col_valid && !win_act;
            out_src    <= line_start ? '0 : src_now;
        end
    end

    // expose the enable flags
    always_comb begin
        layer0_en = flags_q[0];
        layer1_en = flags_q[1];
        sprite_en = flags_q[2];
    end
endmodule

// File: rtl/hws_checker.sv
// Assertion checker for hws_top, attached with bind below.
module hws_checker
    import hws_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               col_valid,
    input logic               line_start,
    input logic [COL_W-1:0]   col,
    input logic               win_act,
    input logic [ACC_W-1:0]   acc_q,
    input logic [SCALE_W-1:0] scale_q,
    input logic [EDGE_W-1:0]  start_q,
    input logic [EDGE_W-1:0]  stop_q,
    input logic               out_valid,
    input logic               out_active,
    input logic               out_border
);
    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (acc_q == '0));                                   // R5
    AST_BORDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !line_start && !win_act) |=> $stable(acc_q));      // R7
    AST_ACTIVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !line_start && win_act) |=>
            (acc_q == $past(acc_q) + ACC_W'($past(scale_q))));           // R6
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_active != out_border));                       // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_active && !out_border));                    // R8
    AST_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && ({2'b00, col} < {start_q, 2'b00})) |=>
            (out_valid && out_border));                                  // R4
    AST_EMPTY_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && (stop_q <= start_q)) |=> out_border);              // R4
endmodule

bind hws_top hws_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .col_valid  (col_valid),
    .line_start (line_start),
    .col        (col),
    .win_act    (win_act),
    .acc_q      (acc_q),
    .scale_q    (scale_q),
    .start_q    (start_q),
    .stop_q     (stop_q),
    .out_valid  (out_valid),
    .out_active (out_active),
    .out_border (out_border)
);

// File: tb/hws_top_tb.sv
module hws_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        col_valid = 1'b0;
    logic [9:0]  col = '0;
    logic        line_start = 1'b0;
    logic        out_valid, out_active, out_border;
    logic [10:0] out_src;
    logic        layer0_en, layer1_en, sprite_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // expected: {active, border, src}
    logic [12:0] exp_q[$];
    string       tag_q[$];

    // bench-side model state
    int m_start = 0, m_stop = 160, m_scale = 128, m_acc = 0;

    always #10 clk = ~clk;

    hws_top u_dut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1 check(req, int'(reg_rdata), exp);
    endtask

    task automatic pulse_line();
        @(negedge clk);
        col_valid = 1'b0; line_start = 1'b1;
        m_acc = 0;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    // drive one column and push its expected result
    task automatic drive_col(input int c, input string req);
        bit a;
        col_valid = 1'b1; col = 10'(c);
        a = (c >= m_start * 4) && (c < m_stop * 4);
        exp_q.push_back({a, ~a, 11'(m_acc >> 7)});
        tag_q.push_back(req);
        if (a) m_acc += m_scale;
        @(negedge clk);
        col_valid = 1'b0;
    endtask

    task automatic drive_line(input int first, input int last, input string req);
        for (int c = first; c <= last; c++) drive_col(c, req);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        check("R8 queue drained", exp_q.size(), 0);
    endtask

    // monitor: compare each produced result against the queue head
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && out_valid) begin
                logic [12:0] e;
                string t;
                if (exp_q.size() == 0) begin
                    check("R8 unexpected output", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({t, " active"}, int'(out_active), int'(e[12]));
                    check({t, " border"}, int'(out_border), int'(e[11]));
                    check({t, " src"},    int'(out_src),    int'(e[10:0]));
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check("R8 idle valid", int'(out_valid), 0);
        // R1 reset state through R2 map
        rd_chk(2'd0, 0,   "R1 bank");
        rd_chk(2'd1, 0,   "R1 flags");
        rd_chk(2'd2, 128, "R1 scale");
        check("R1 layer0", int'(layer0_en), 0);
        wr(2'd0, 8'h01);
        rd_chk(2'd0, 1,   "R2 bank set");
        rd_chk(2'd1, 0,   "R1 start");
        rd_chk(2'd2, 160, "R1 stop");
        wr(2'd0, 8'h00);
        // R3 flags
        wr(2'd1, 8'hFF);
        rd_chk(2'd1, 8'h70, "R3 readback");
        check("R3 layer0", int'(layer0_en), 1);
        check("R3 layer1", int'(layer1_en), 1);
        check("R3 sprite", int'(sprite_en), 1);
        wr(2'd1, 8'h20);
        check("R3 only layer1 l0", int'(layer0_en), 0);
        check("R3 only layer1 l1", int'(layer1_en), 1);
        check("R3 only layer1 sp", int'(sprite_en), 0);
        // R2 bank steering: bank0 write to addr1 leaves start untouched
        wr(2'd0, 8'h01);
        rd_chk(2'd1, 0, "R2 start untouched");
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h55);
        rd_chk(2'd3, 0, "R2 addr3");
        rd_chk(2'd2, 128, "R2 scale after addr3 write");
        // R6 identity line
        pulse_line();
        drive_line(0, 639, "R6 identity");
        drain();
        // R6 doubling
        wr(2'd2, 8'd64); m_scale = 64;
        pulse_line();
        drive_line(0, 639, "R6 double");
        drain();
        // R7 narrow window with fractional step
        wr(2'd2, 8'd96); m_scale = 96;
        wr(2'd0, 8'h01);
        wr(2'd1, 8'd10); m_start = 10;
        wr(2'd2, 8'd100); m_stop = 100;
        pulse_line();
        drive_line(0, 639, "R7 window");
        drain();
        // R7 gap in the middle of a line: border columns hold accumulator
        pulse_line();
        drive_line(40, 100, "R7 pre-gap");
        drive_line(500, 520, "R7 gap");
        m_start = 0; wr(2'd1, 8'd0);
        drive_line(0, 30, "R7 resume");
        drain();
        // R5 restart mid-line
        wr(2'd2, 8'd160); m_stop = 160;
        wr(2'd0, 8'h00);
        wr(2'd2, 8'd255); m_scale = 255;
        pulse_line();
        drive_line(0, 200, "R6 max step");
        pulse_line();
        drive_line(201, 300, "R5 restart");
        drain();
        // R4 empty window
        wr(2'd0, 8'h01);
        wr(2'd1, 8'd80); m_start = 80;
        wr(2'd2, 8'd80); m_stop = 80;
        pulse_line();
        drive_line(0, 639, "R4 empty");
        drain();
        @(negedge clk);
        #1 check("R8 idle flags", int'(out_active | out_border), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (60000) @(posedge clk);
                check("watchdog", 1, 0);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule